// File: doc/BRIEF.md
# Tachometer Speed Discriminator with Lock Detect

This block judges whether a motor runs too fast or too slow. It counts reference-clock enables over a window of two tachometer periods and compares the result with a target count that two select pins choose. The reference enable runs at the commanded speed frequency multiplied by the target count. At the target speed, therefore, the halved tick count over two tachometer periods equals the target exactly. Generating the reference frequency and integrating the error into a torque command are left to the surrounding logic.

Each time a window closes, the block issues a one-cycle strobe. With the strobe it updates two outputs. The first is a direction output: high asks for acceleration and low reports overspeed. The second is an active-low lock flag, which is low while the measured count lies within one sixteenth of the target. A stalled motor never closes its window, so the count saturates at twice the target. A saturated count reads as underspeed and out of lock.

Top module: `tach_speed_disc`

## Requirements
- R1: The target count N comes from the select pins: sel_a=1,sel_b=1 gives 64; sel_a=0,sel_b=1 gives 128; sel_a=1,sel_b=0 gives 256; sel_a=0,sel_b=0 gives 512 (BASE_N=64).
- R2: The measured count is the number of ref_tick cycles inside a window, divided by two and rounded down. A window spans two tachometer periods: it opens at one fg_pulse and closes two fg_pulse cycles later. ref_tick in the cycle of an opening or closing fg_pulse is not counted.
- R3: The measured count saturates at 2N. A saturated result gives speed_up=1 and lock_n=1.
- R4: At each window close, speed_up becomes 0 if the count is below N and 1 otherwise.
- R5: At each window close, lock_n becomes 0 when N - N/16 <= count <= N + N/16, and 1 otherwise.
- R6: err_stb is high for exactly the one cycle after each window-closing fg_pulse. speed_up and lock_n change only in that cycle.
- R7: During reset, and after it, speed_up=1, lock_n=1 and err_stb=0. The first fg_pulse after reset only opens a window, so no strobe follows until the third pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | Reference frequency enable, one cycle per reference edge |
| fg_pulse | input | 1 | Synchronised tachometer pulse, one cycle per tachometer period |
| sel_a | input | 1 | Target count select, low bit of the inverted code |
| sel_b | input | 1 | Target count select, high bit of the inverted code |
| speed_up | output | 1 | 1 = underspeed, accelerate; 0 = overspeed |
| err_stb | output | 1 | One-cycle strobe marking a new result |
| lock_n | output | 1 | Active-low lock flag, low inside the ±N/16 window |

## Verification
The bench drives windows whose counts land exactly on N, on N-1, and on each side of both lock edges, for every select setting. A comparison off by one, or a lock bound computed from the wrong shift, shows up there as a flipped direction or lock bit. Stalled windows running far past 2N catch a counter that wraps instead of saturating; a wrapping counter would report a stalled motor as overspeed or locked. Checks right after reset and on the first two pulses catch a design that closes a window on the first pulse, which would issue a strobe carrying a count from before the motor was seen.

// File: rtl/tdisc_pkg.sv
`timescale 1ns/1ps
package tdisc_pkg;
  // Overspeed when fewer halved ticks than the target were seen.
  function automatic logic is_fast(input int unsigned count, input int unsigned tgt);
    return count < tgt;
  endfunction

  // Lock band of one sixteenth of the target on each side.
  function automatic logic in_band(input int unsigned count, input int unsigned tgt);
    int unsigned margin;
    margin = tgt >> 4;
    return (count + margin >= tgt) && (count <= tgt + margin);
  endfunction
endpackage

// File: rtl/tdisc_phase.sv
`timescale 1ns/1ps
module tdisc_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic fg_pulse,
  output logic win_start,
  output logic win_end
);
  logic armed;
  logic mid;

  assign win_start = fg_pulse & (~armed | mid);
  assign win_end   = fg_pulse & armed & mid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      mid   <= 1'b0;
    end else if (fg_pulse) begin
      if (!armed) begin
        armed <= 1'b1;
        mid   <= 1'b0;
      end else begin
        mid <= ~mid;
      end
    end
  end

  // R6: two closing pulses never follow each other directly
  p_end_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> !win_end);
endmodule

// File: rtl/tdisc_counter.sv
`timescale 1ns/1ps
module tdisc_counter #(
  parameter int CNT_W = 11,
  parameter int MAX_N = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             clr,
  input  logic [CNT_W-1:0] sat_lim,
  output logic [CNT_W-1:0] cnt,
  output logic             cnt_sat
);
  logic half;

  assign cnt_sat = cnt >= sat_lim;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt  <= '0;
      half <= 1'b0;
    end else if (ref_tick) begin
      half <= ~half;
      if (half && !cnt_sat) cnt <= cnt + 1'b1;
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) <= 2 * MAX_N);
  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);
endmodule

// File: rtl/tdisc_judge.sv
`timescale 1ns/1ps
module tdisc_judge #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_end,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] tgt,
  output logic             speed_up,
  output logic             lock_n,
  output logic             err_stb
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      speed_up <= 1'b1;
      lock_n   <= 1'b1;
      err_stb  <= 1'b0;
    end else begin
      err_stb <= win_end;
      if (win_end) begin
        speed_up <= ~tdisc_pkg::is_fast(32'(cnt), 32'(tgt));
        lock_n   <= ~tdisc_pkg::in_band(32'(cnt), 32'(tgt));
      end
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !err_stb |-> $stable(speed_up) && $stable(lock_n));
  p_stb_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_stb |=> !err_stb);
endmodule

// File: rtl/tach_speed_disc.sv
`timescale 1ns/1ps
module tach_speed_disc #(
  parameter int BASE_N = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic fg_pulse,
  input  logic sel_a,
  input  logic sel_b,
  output logic speed_up,
  output logic err_stb,
  output logic lock_n
);
  localparam int CODE_W = 2;
  localparam int MAX_N  = BASE_N << ((1 << CODE_W) - 1);
  localparam int CNT_W  = $clog2(2 * MAX_N + 1);

  logic [CODE_W-1:0] code;
  logic [CNT_W-1:0]  tgt;
  logic [CNT_W-1:0]  sat_lim;
  logic [CNT_W-1:0]  cnt;
  logic              cnt_sat;
  logic              win_start;
  logic              win_end;

  // R1: pins are inverted into a shift amount on the base count
  assign code    = {~sel_b, ~sel_a};
  assign tgt     = CNT_W'(BASE_N) << code;
  assign sat_lim = tgt << 1;

  tdisc_phase u_phase (
    .clk(clk), .rst_n(rst_n), .fg_pulse(fg_pulse),
    .win_start(win_start), .win_end(win_end)
  );

  tdisc_counter #(.CNT_W(CNT_W), .MAX_N(MAX_N)) u_count (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .clr(win_start),
    .sat_lim(sat_lim), .cnt(cnt), .cnt_sat(cnt_sat)
  );

  tdisc_judge #(.CNT_W(CNT_W)) u_judge (
    .clk(clk), .rst_n(rst_n), .win_end(win_end), .cnt(cnt), .tgt(tgt),
    .speed_up(speed_up), .lock_n(lock_n), .err_stb(err_stb)
  );

  p_sat_slow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err_stb && $past(cnt_sat) |-> speed_up && lock_n);
  p_first_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(win_start && !win_end) |-> !err_stb);
  p_strobe_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_stb |-> $past(fg_pulse));
endmodule

// File: tb/tach_speed_disc_bench.sv
`timescale 1ns/1ps
module tach_speed_disc_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_tick = 1'b0;
  logic fg_pulse = 1'b0;
  logic sel_a = 1'b1;
  logic sel_b = 1'b1;
  logic speed_up, err_stb, lock_n;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string ctx = "R6";

  // bench model state
  bit m_armed, m_mid;
  int m_ticks;
  bit e_up = 1'b1, e_lock_n = 1'b1, e_stb = 1'b0;

  always #2 clk = ~clk;

  tach_speed_disc u_tach_speed_disc (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .fg_pulse(fg_pulse),
    .sel_a(sel_a), .sel_b(sel_b), .speed_up(speed_up), .err_stb(err_stb),
    .lock_n(lock_n)
  );

  // R1: target table written out from the pin encoding
  function automatic int target_n(bit a, bit b);
    if (a && b) return 64;
    if (!a && b) return 128;
    if (a && !b) return 256;
    return 512;
  endfunction

  function automatic int measured(int ticks, int n);
    int c;
    c = ticks / 2;
    return (c > 2 * n) ? 2 * n : c;
  endfunction

  task automatic chk(bit act, bit exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", ctx, what, act, exp);
    end
  endtask

  task automatic step(bit r, bit f);
    int n, c;
    ref_tick = r;
    fg_pulse = f;
    e_stb = 1'b0;
    if (f) begin
      if (!m_armed) begin
        m_armed = 1'b1; m_mid = 1'b0; m_ticks = 0;
      end else if (!m_mid) begin
        m_mid = 1'b1;
        if (r) m_ticks++;
      end else begin
        n = target_n(sel_a, sel_b);
        c = measured(m_ticks, n);
        e_stb = 1'b1;
        e_up = (c >= n);
        e_lock_n = !((c >= n - n / 16) && (c <= n + n / 16));
        m_mid = 1'b0; m_ticks = 0;
      end
    end else if (r) begin
      m_ticks++;
    end
    @(negedge clk);
    chk(err_stb, e_stb, "R6 err_stb");
    chk(speed_up, e_up, "R4 speed_up");
    chk(lock_n, e_lock_n, "R5 lock_n");
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ref_tick = 1'b0; fg_pulse = 1'b0;
    repeat (3) @(negedge clk);
    m_armed = 0; m_mid = 0; m_ticks = 0;
    e_up = 1; e_lock_n = 1; e_stb = 0;
    ctx = "R7 reset";
    chk(speed_up, 1'b1, "speed_up");
    chk(lock_n, 1'b1, "lock_n");
    chk(err_stb, 1'b0, "err_stb");
    rst_n = 1'b1;
  endtask

  task automatic ticks(int t, int idle_pct);
    for (int i = 0; i < t; i++) begin
      while (idle_pct > 0 && ($urandom % 100) < idle_pct) step(0, 0);
      step(1, 0);
    end
  endtask

  // a window whose halved tick count is c, ending in its closing pulse
  task automatic window(int c, int idle_pct);
    int t1;
    t1 = c;
    ticks(t1, idle_pct);
    step(0, 1);
    ticks(2 * c - t1 + ($urandom % 2), idle_pct);
    step(0, 1);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    do_reset();
    // R7: first and second pulses bring no strobe
    ctx = "R7 first pulse";
    step(0, 1);
    ticks(64, 0);
    step(0, 1);
    ticks(64, 0);
    ctx = "R2 R4 exact target 64";
    step(0, 1);
    for (int s = 0; s < 4; s++) begin
      int n;
      sel_a = !s[0]; sel_b = !s[1];
      n = target_n(sel_a, sel_b);
      ctx = $sformatf("R1 sel %0d target %0d", s, n);
      window(n, 0);          // result from a window partly before change is skipped by design? no: sel set at boundary
      ctx = "R4 one below target";
      window(n - 1, 0);
      ctx = "R5 lower lock edge";
      window(n - n / 16, 0);
      ctx = "R5 below lower edge";
      window(n - n / 16 - 1, 0);
      ctx = "R5 upper lock edge";
      window(n + n / 16, 0);
      ctx = "R5 above upper edge";
      window(n + n / 16 + 1, 0);
      ctx = "R3 stalled motor";
      window(3 * n, 0);
      ctx = "R2 locked after stall";
      window(n, 0);
    end
    // R7: reset in the middle of a window
    ticks(30, 0);
    step(0, 1);
    do_reset();
    ctx = "R7 restart";
    step(0, 1);
    ticks(40, 0);
    step(0, 1);
    ctx = "R2 random windows";
    step(0, 1);
    sel_a = 1; sel_b = 1;
    for (int k = 0; k < 60; k++) begin
      int n, c;
      n = target_n(sel_a, sel_b);
      c = n - n / 8 + int'($urandom % (n / 4 + 1));
      window(c, int'($urandom % 30));
      if (k % 10 == 9) begin
        sel_a = $urandom % 2; sel_b = $urandom % 2;
        if (!sel_a && !sel_b) sel_b = 1;
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule